// File: doc/BRIEF.md
# SPI Boot Image Loader

This block fills system SRAM with a boot image before the processor is allowed to run. It acts as SPI master towards an external storage controller. After reset it selects the controller, clocks out a one-byte read request, and then receives the image. The image arrives in batches. The controller needs time to fetch each batch, so before every batch the loader keeps SCLK running and waits for MISO to show a single 1. That 1 is the start bit. The data bits of the batch follow from the next SCLK edge on.

Each received byte is written through a one-cycle write strobe to the next SRAM address, counting up from a fixed base (0xF000 by default). When the last byte of the image has been written, the loader deselects the controller, stops SCLK, and in the same cycle releases the processor's active-low reset and gives it the memory bus. It stays in that state until the next reset. SCLK runs at the system clock divided by 2×HALF_DIV, and HALF_DIV must be at least 2.

Top module: `spi_image_loader`

## Requirements
- R1: While reset is high and in the first cycle after it, cs_n is 1, sclk is 0, mem_we is 0, cpu_rst_n is 0, bus_to_cpu is 0 and done is 0.
- R2: After reset, cs_n goes low and the first 8 rising SCLK edges carry CMD_BYTE (default 8'h03) on MOSI, most significant bit first. MOSI changes only while SCLK is low (SPI mode 0).
- R3: SCLK idles low. While the loader is active, successive rising SCLK edges are exactly 2×HALF_DIV clock cycles apart.
- R4: After the command, and again after every complete batch, the loader samples MISO on each rising SCLK edge and ignores any number of 0s, including none. The first 1 is the start bit, and the first data bit is sampled on the next rising edge.
- R5: Data bits are assembled most significant bit first. Each batch holds BATCH_BYTES bytes, except the final batch, which holds the remainder of IMAGE_BYTES. No start bit is expected inside a batch.
- R6: Every image byte is written exactly once, with mem_we high for a single cycle. Byte k goes to address BASE_ADDR + k, so the first write is to BASE_ADDR and each later write is one above the one before.
- R7: done rises in the clock cycle right after the write strobe of byte IMAGE_BYTES−1, and it stays high until reset.
- R8: cpu_rst_n and bus_to_cpu stay 0 until done rises, and they switch to 1 in the same cycle as done. No write strobe occurs while either of them is 1.
- R9: Once done is high, cs_n is 1, sclk stays 0 and mem_we stays 0, whatever MISO does.
- R10: Asserting reset after a finished load starts a complete new load, beginning with the command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | output | 1 | SPI serial clock, mode 0 |
| cs_n | output | 1 | Storage controller select, active low |
| mosi | output | 1 | Serial data to the controller (read command) |
| miso | input | 1 | Serial data from the controller (start bits and image) |
| mem_we | output | 1 | SRAM write strobe, one cycle per byte |
| mem_addr | output | ADDR_W | SRAM write address |
| mem_wdata | output | DATA_W | SRAM write data |
| cpu_rst_n | output | 1 | Processor reset, active low, released when the load is done |
| bus_to_cpu | output | 1 | 1 when the processor owns the memory bus |
| done | output | 1 | Image fully written |

## Verification
The assertions check, on every cycle, the rules that hold regardless of the incoming data. These are the ascending write addresses starting at the base, single-cycle strobes, completion directly after the final address, a sticky done, a quiet SPI port after handover, and SCLK edges only while selected. Three behaviours can only be shown by the bench scenarios, because they depend on what the controller sends. These are correct byte values, start-bit hunting across gaps of zero and many bit times, and batch boundaries where a short last batch follows full ones. The bench also covers the command byte on MOSI, the SCLK period, and a restart after a second reset.

// File: rtl/spi_loader_pkg.sv
package spi_loader_pkg;
  typedef enum logic [1:0] {
    LD_CMD  = 2'd0,
    LD_HUNT = 2'd1,
    LD_DATA = 2'd2,
    LD_DONE = 2'd3
  } ld_state_t;
endpackage

// File: rtl/spi_clk_gen.sv
module spi_clk_gen #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sclk,
  output logic rise,
  output logic fall
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      sclk <= 1'b0;
      rise <= 1'b0;
      fall <= 1'b0;
    end else begin
      rise <= 1'b0;
      fall <= 1'b0;
      if (cnt == CW'(HALF_DIV - 1)) begin
        cnt  <= '0;
        sclk <= ~sclk;
        rise <= ~sclk;
        fall <= sclk;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
  parameter int unsigned W       = 8,
  parameter logic [W-1:0] TX_INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_tx,
  input  logic         shift_rx,
  input  logic         miso,
  output logic         mosi,
  output logic [W-1:0] rx_next
);
  logic [W-1:0] tx_sr;
  logic [W-1:0] rx_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr <= TX_INIT;
      rx_sr <= '0;
    end else begin
      if (shift_tx) tx_sr <= {tx_sr[W-2:0], 1'b0};
      if (shift_rx) rx_sr <= rx_next;
    end
  end

  assign mosi    = tx_sr[W-1];
  assign rx_next = {rx_sr[W-2:0], miso};
endmodule

// File: rtl/spi_image_loader.sv
module spi_image_loader
  import spi_loader_pkg::*;
#(
  parameter int unsigned HALF_DIV    = 4,
  parameter int unsigned BATCH_BYTES = 512,
  parameter int unsigned IMAGE_BYTES = 4096,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned BASE_ADDR   = 'hF000,
  parameter int unsigned CMD_BYTE    = 'h03
) (
  input  logic              clk,
  input  logic              rst,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              cpu_rst_n,
  output logic              bus_to_cpu,
  output logic              done
);
  localparam int unsigned IDX_W   = (IMAGE_BYTES > 1) ? $clog2(IMAGE_BYTES) : 1;
  localparam int unsigned BATCH_W = (BATCH_BYTES > 1) ? $clog2(BATCH_BYTES) : 1;
  localparam int unsigned BIT_W   = $clog2(DATA_W);
  localparam logic [IDX_W-1:0]   LAST_BYTE  = IDX_W'(IMAGE_BYTES - 1);
  localparam logic [BATCH_W-1:0] LAST_BATCH = BATCH_W'(BATCH_BYTES - 1);
  localparam logic [BIT_W-1:0]   LAST_BIT   = BIT_W'(DATA_W - 1);

  ld_state_t          state;
  logic [BIT_W-1:0]   bit_idx;
  logic [IDX_W-1:0]   byte_idx;
  logic [BATCH_W-1:0] batch_idx;
  logic               done_q;
  logic               run;
  logic               sclk_rise;
  logic               sclk_fall;
  logic [DATA_W-1:0]  rx_next;

  assign run = (state != LD_DONE);

  spi_clk_gen #(.HALF_DIV(HALF_DIV)) u_clk_gen (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .sclk (sclk),
    .rise (sclk_rise),
    .fall (sclk_fall)
  );

  spi_shift_unit #(
    .W       (DATA_W),
    .TX_INIT (DATA_W'(CMD_BYTE))
  ) u_shift (
    .clk      (clk),
    .rst      (rst),
    .shift_tx (sclk_fall && state == LD_CMD),
    .shift_rx (sclk_rise && state == LD_DATA),
    .miso     (miso),
    .mosi     (mosi),
    .rx_next  (rx_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= LD_CMD;
      bit_idx   <= '0;
      byte_idx  <= '0;
      batch_idx <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      cs_n      <= 1'b1;
      done_q    <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      cs_n   <= (state == LD_DONE);
      done_q <= (state == LD_DONE);
      case (state)
        LD_CMD: begin
          if (sclk_rise) begin
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx == LAST_BIT) begin
              bit_idx <= '0;
              state   <= LD_HUNT;
            end
          end
        end
        LD_HUNT: begin
          if (sclk_rise && miso) state <= LD_DATA;
        end
        LD_DATA: begin
          if (sclk_rise) begin
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx == LAST_BIT) begin
              bit_idx   <= '0;
              mem_we    <= 1'b1;
              mem_wdata <= rx_next;
              mem_addr  <= ADDR_W'(BASE_ADDR) + ADDR_W'(byte_idx);
              byte_idx  <= byte_idx + 1'b1;
              if (byte_idx == LAST_BYTE) begin
                state <= LD_DONE;
              end else if (batch_idx == LAST_BATCH) begin
                batch_idx <= '0;
                state     <= LD_HUNT;
              end else begin
                batch_idx <= batch_idx + 1'b1;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign done       = done_q;
  assign cpu_rst_n  = done_q;
  assign bus_to_cpu = done_q;
endmodule

// File: rtl/spi_image_loader_chk.sv
module spi_image_loader_chk #(
  parameter int unsigned IMAGE_BYTES = 4096,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned BASE_ADDR   = 'hF000
) (
  input logic              clk,
  input logic              rst,
  input logic              sclk,
  input logic              cs_n,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              cpu_rst_n,
  input logic              bus_to_cpu,
  input logic              done
);
  logic              seen_wr;
  logic [ADDR_W-1:0] prev_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_wr   <= 1'b0;
      prev_addr <= '0;
    end else if (mem_we) begin
      seen_wr   <= 1'b1;
      prev_addr <= mem_addr;
    end
  end

  assert_first_addr_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !seen_wr) |-> mem_addr == ADDR_W'(BASE_ADDR));

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_we && seen_wr) |-> mem_addr == prev_addr + 1'b1);

  assert_single_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(mem_we) && $past(mem_addr) == ADDR_W'(BASE_ADDR + IMAGE_BYTES - 1)));

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  assert_no_write_after_handover_R8: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (!cpu_rst_n && !bus_to_cpu && !done));

  assert_quiet_port_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (cs_n && !sclk));

  assert_sclk_selected_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> !cs_n);
endmodule

bind spi_image_loader spi_image_loader_chk #(
  .IMAGE_BYTES (IMAGE_BYTES),
  .ADDR_W      (ADDR_W),
  .BASE_ADDR   (BASE_ADDR)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sclk       (sclk),
  .cs_n       (cs_n),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .cpu_rst_n  (cpu_rst_n),
  .bus_to_cpu (bus_to_cpu),
  .done       (done)
);

// File: tb/spi_image_loader_bench.sv
`timescale 1ns/1ps
module spi_image_loader_bench;
  localparam int HALF  = 2;
  localparam int BATCH = 4;
  localparam int IMAGE = 10;
  localparam int NB    = (IMAGE + BATCH - 1) / BATCH;
  localparam int BASE  = 'hF000;
  localparam int CMD   = 'h03;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        miso = 1'b0;
  logic        sclk, cs_n, mosi, mem_we, cpu_rst_n, bus_to_cpu, done;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  int writes_seen = 0;
  int last_rise = -1;
  logic exp_done = 1'b0;
  logic sclk_prev = 1'b0;
  logic mosi_prev = 1'b0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  spi_image_loader #(
    .HALF_DIV    (HALF),
    .BATCH_BYTES (BATCH),
    .IMAGE_BYTES (IMAGE),
    .ADDR_W      (16),
    .DATA_W      (8),
    .BASE_ADDR   (BASE),
    .CMD_BYTE    (CMD)
  ) u_spi_image_loader (
    .clk, .rst, .sclk, .cs_n, .mosi, .miso, .mem_we, .mem_addr,
    .mem_wdata, .cpu_rst_n, .bus_to_cpu, .done
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // reference model: every clock, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      check(done == exp_done, "R7 done", done, exp_done);
      check(cpu_rst_n == exp_done && bus_to_cpu == exp_done, "R8 handover",
            {cpu_rst_n, bus_to_cpu}, {exp_done, exp_done});
      if (exp_done)
        check(cs_n && !sclk && !mem_we, "R9 quiet after done",
              {cs_n, sclk, mem_we}, 3'b100);
      if (sclk && sclk_prev)
        check(mosi == mosi_prev, "R2 mosi stable while sclk high", mosi, mosi_prev);
      if (sclk && !sclk_prev) begin
        if (last_rise >= 0)
          check(cyc - last_rise == 2 * HALF, "R3 sclk period", cyc - last_rise, 2 * HALF);
        last_rise = cyc;
      end
      if (mem_we) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected write", mem_addr, 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(mem_wdata == e, "R5 byte value", mem_wdata, e);
          check(mem_addr == 16'(BASE + writes_seen), "R6 address", mem_addr, BASE + writes_seen);
        end
        writes_seen++;
        if (writes_seen == IMAGE) exp_done = 1'b1;
      end
    end
    sclk_prev = sclk;
    mosi_prev = mosi;
  end

  task automatic send_bit(input logic b);
    @(negedge sclk);
    miso = b;
  endtask

  function automatic logic [7:0] pattern(input int run, input int k);
    if (k == 0) return 8'hFF;
    if (k == 1) return 8'h00;
    return 8'((k * 37 + run * 91 + 5) & 255);
  endfunction

  task automatic slave_run(input int run, input int g0, input int g1, input int g2);
    logic [7:0] c = '0;
    int gaps[3];
    int idx = 0;
    gaps[0] = g0; gaps[1] = g1; gaps[2] = g2;
    for (int i = 0; i < 8; i++) begin
      @(posedge sclk);
      c = {c[6:0], mosi};
    end
    check(c == 8'(CMD), "R2 command byte", c, CMD);
    for (int b = 0; b < NB; b++) begin
      int n;
      // R4: gap of zeros then a start bit
      for (int g = 0; g < gaps[b % 3]; g++) send_bit(1'b0);
      send_bit(1'b1);
      n = (IMAGE - idx < BATCH) ? IMAGE - idx : BATCH;
      for (int k = 0; k < n; k++) begin
        logic [7:0] v;
        v = pattern(run, idx);
        exp_q.push_back(v);
        idx++;
        for (int bi = 7; bi >= 0; bi--) send_bit(v[bi]);
      end
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    miso = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(cs_n && !sclk && !mem_we && !cpu_rst_n && !bus_to_cpu && !done, "R1 reset state",
          {cs_n, sclk, mem_we, cpu_rst_n, bus_to_cpu, done}, 6'b100000);
    exp_q.delete();
    writes_seen = 0;
    exp_done = 1'b0;
    last_rise = -1;
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(!done && !cpu_rst_n && !mem_we, "R1 first cycle after reset",
          {done, cpu_rst_n, mem_we}, 0);
  endtask

  task automatic run_load(input int run, input int g0, input int g1, input int g2);
    slave_run(run, g0, g1, g2);
    wait (done === 1'b1);
    repeat (2) @(negedge clk);
    // R9: toggle MISO after handover and look for any reaction
    for (int i = 0; i < 40; i++) begin
      @(posedge clk);
      miso = ~miso;
    end
    @(negedge clk);
    check(writes_seen == IMAGE, "R5 total bytes written", writes_seen, IMAGE);
    check(exp_q.size() == 0, "R5 all bytes consumed", exp_q.size(), 0);
    check(done && cs_n && !sclk, "R9 idle after load", {done, cs_n, sclk}, 3'b110);
  endtask

  initial begin
    do_reset();
    run_load(0, 0, 5, 1);
    // R10: a second reset restarts a full load
    do_reset();
    run_load(1, 30, 0, 2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule